// File: doc/BRIEF.md
# Sync-Word Gated Bit Receive FIFO

This block sits behind a packet-radio demodulator. It accepts one received bit for each cycle in which `bit_valid` is high. It can hunt for the 16-bit synchronisation word 0x2DD4 and store the bits that follow it. It can also store every bit it receives, with no hunt at all. The stored bits queue in a small bit-granular FIFO. A level interrupt tells the host controller when enough bits have gathered.

The controller talks to the block through 16-bit command words. A word whose upper byte is 0xCA rewrites the configuration: the interrupt level, the start mode, the fill enable and one supply-glitch reset option. The glitch option is only stored and passed to an output. The word 0xB000 pops one byte. The popped byte appears one cycle later on the response port. A pop takes effect only while the separate `fifo_en` input is high.

After a sync match the hunt stays locked, and later copies of the sync word are stored as ordinary data. To hunt again, the controller clears the fill-enable bit and then sets it again.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset the configuration equals the word 0xCA80: fill level 8, sync-start mode, filling off and glitch option 0. The FIFO is empty, and `irq`, `fifo_ovf`, `rsp_valid` and `glitch_rst_off` are low. Bits received in this state are not stored.
- R2: A command with upper byte 0xCA loads the configuration from the word: bits 7..4 set the fill level, bit 2 sets the start mode (1 = store always), bit 1 is the fill enable and bit 0 is the glitch option. Bit 3 is ignored. Any other command leaves the configuration unchanged.
- R3: In sync-start mode with filling enabled, bits enter MSB first. Storing begins with the first bit after the most recent 16 bits equal 0x2DD4. A match needs at least 16 bits received since the hunt was armed. The sync bits themselves are not stored.
- R4: In store-always mode with filling enabled, every valid bit is stored.
- R5: Once a configuration write clears the fill enable, no later bit is stored.
- R6: After a match, further sync patterns are stored as data. Clearing the fill enable and then setting it again re-arms the hunt.
- R7: `irq` is high exactly while the stored bit count is at least the fill level, where a level of 0 counts as 1. It falls in the same cycle as the read that takes the count below the level.
- R8: The command 0xB000 with `fifo_en` high pulses `rsp_valid` in the next cycle. `rsp_data` then holds the oldest 8 bits, with the oldest bit in bit 7, and the count drops by 8.
- R9: A read of fewer than 8 stored bits returns them left-aligned and padded with zeros, and it empties the FIFO.
- R10: A read with `fifo_en` low returns 0 with `rsp_valid` high and leaves the stored bits unchanged.
- R11: The FIFO holds 16 bits. A bit that arrives while it is full is dropped and sets the sticky `fifo_ovf` flag. An honoured read clears the flag.
- R12: Configuration bit 0 appears on `glitch_rst_off` and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: `bit_data` carries a received bit |
| bit_data | input | 1 | Received bit |
| cmd_valid | input | 1 | Strobe: `cmd_word` carries a command |
| cmd_word | input | 16 | Command word |
| fifo_en | input | 1 | Allows read commands to pop |
| rsp_valid | output | 1 | One-cycle pulse after any read command |
| rsp_data | output | 8 | Popped byte, oldest bit in bit 7 |
| irq | output | 1 | High while the stored count is at or above the fill level |
| fifo_ovf | output | 1 | Sticky flag: a bit was dropped because the FIFO was full |
| glitch_rst_off | output | 1 | Stored glitch-reset option bit |

## Verification
The bench builds the block with its defaults: a 16-bit FIFO, 8-bit reads and the 16-bit sync word. At this size every fill level can be swept against every count from 0 to 16, so all interrupt thresholds are compared with the count the bench derives from its own bit queue. The small depth also makes the full-FIFO drop and the partial, zero-padded read cheap to reach. A 16-bit hunt window lets the bench send a 14-bit prefix that would match against a cleared history, which shows that a match waits for 16 received bits.

// File: rtl/sync_rx_fifo_pkg.sv
package sync_rx_fifo_pkg;

  localparam int unsigned LEVEL_W = 4;
  localparam logic [7:0]  CFG_OPCODE = 8'hCA;
  localparam logic [15:0] READ_CMD   = 16'hB000;
  localparam logic [15:0] CFG_POR    = 16'hCA80;

  typedef struct packed {
    logic [LEVEL_W-1:0] level;
    logic               start_always;
    logic               fill_en;
    logic               rst_sens_off;
  } rx_cfg_t;

  // Field extraction from {word[7:4], word[2:0]}; bit 3 is reserved.
  function automatic rx_cfg_t cfg_unpack(input logic [LEVEL_W+2:0] f);
    rx_cfg_t c;
    c.level        = f[LEVEL_W+2:3];
    c.start_always = f[2];
    c.fill_en      = f[1];
    c.rst_sens_off = f[0];
    return c;
  endfunction

  // Effective interrupt threshold: a level of zero behaves as one.
  function automatic logic [LEVEL_W:0] irq_threshold(input logic [LEVEL_W-1:0] lvl);
    return (lvl == '0) ? (LEVEL_W+1)'(1) : {1'b0, lvl};
  endfunction

endpackage

// File: rtl/sfifo_cmd_decode.sv
module sfifo_cmd_decode
  import sync_rx_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  output rx_cfg_t     cfg,
  output logic        cfg_wr,
  output logic        rd_req
);

  assign cfg_wr = cmd_valid && (cmd_word[15:8] == CFG_OPCODE);
  assign rd_req = cmd_valid && (cmd_word == READ_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= cfg_unpack({CFG_POR[7:4], CFG_POR[2:0]});
    end else if (cfg_wr) begin
      cfg <= cfg_unpack({cmd_word[7:4], cmd_word[2:0]});
    end
  end

endmodule

// File: rtl/sfifo_sync_hunt.sv
module sfifo_sync_hunt #(
  parameter int unsigned   SYNC_W    = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic fill_en,
  input  logic start_always,
  output logic gate_open,
  output logic sync_hit,
  output logic locked
);

  localparam int unsigned HW = $clog2(SYNC_W + 1);
  localparam logic [HW-1:0] SEEN_NEED = HW'(SYNC_W - 1);

  logic [SYNC_W-2:0] hist_q;
  logic [HW-1:0]     seen_q;
  logic [SYNC_W-1:0] window;
  logic              searching;
  logic              enough;

  assign searching = fill_en && !start_always && !locked;
  assign window    = {hist_q, bit_data};
  assign enough    = (seen_q >= SEEN_NEED);
  assign sync_hit  = searching && bit_valid && enough && (window == SYNC_WORD);
  assign gate_open = fill_en && (start_always || locked);

  always_ff @(posedge clk) begin
    if (!rst_n || !searching) begin
      hist_q <= '0;
      seen_q <= '0;
    end else if (bit_valid) begin
      hist_q <= window[SYNC_W-2:0];
      if (!enough) seen_q <= seen_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fill_en) locked <= 1'b0;
    else if (sync_hit)      locked <= 1'b1;
  end

endmodule

// File: rtl/sfifo_bit_store.sv
module sfifo_bit_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              push_bit,
  input  logic              pop_req,
  output logic [BYTE_W-1:0] pop_data,
  output logic [CW-1:0]     fill_count,
  output logic              push_ok,
  output logic              push_drop,
  output logic              ovf
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] BYTE_C = CW'(BYTE_W);

  logic [DEPTH-1:0] bits_q, bits_mid, bits_d;
  logic [CW-1:0]    cnt_mid;

  // Count left after removing one byte, never below zero.
  function automatic logic [CW-1:0] after_pop(input logic [CW-1:0] c);
    return (c > BYTE_C) ? (c - BYTE_C) : '0;
  endfunction

  assign pop_data  = bits_q[DEPTH-1 -: BYTE_W];
  assign cnt_mid   = pop_req ? after_pop(fill_count) : fill_count;
  assign bits_mid  = pop_req ? (bits_q << BYTE_W) : bits_q;
  assign push_ok   = push_req && (cnt_mid < FULL_C);
  assign push_drop = push_req && (cnt_mid == FULL_C);

  // Unused positions are kept at zero, so a short pop pads with zeros.
  always_comb begin
    bits_d = bits_mid;
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && (CW'(DEPTH - 1 - i) == cnt_mid)) bits_d[i] = push_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q     <= '0;
      fill_count <= '0;
      ovf        <= 1'b0;
    end else begin
      bits_q     <= bits_d;
      fill_count <= cnt_mid + (push_ok ? CW'(1) : CW'(0));
      if (push_drop)    ovf <= 1'b1;
      else if (pop_req) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_fifo_pkg::*;
#(
  parameter int unsigned       DEPTH     = 16,
  parameter int unsigned       BYTE_W    = 8,
  parameter int unsigned       SYNC_W    = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_word,
  input  logic              fifo_en,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              irq,
  output logic              fifo_ovf,
  output logic              glitch_rst_off
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_cfg_t           cfg;
  logic              cfg_wr, rd_req, pop_go;
  logic              cfg_fill_en;
  logic              gate_open, sync_hit, locked;
  logic              push_ok, push_drop;
  logic [CW-1:0]     fill_count;
  logic [BYTE_W-1:0] pop_data;

  sfifo_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .cfg       (cfg),
    .cfg_wr    (cfg_wr),
    .rd_req    (rd_req)
  );

  assign cfg_fill_en    = cfg.fill_en;
  assign glitch_rst_off = cfg.rst_sens_off;
  assign pop_go         = rd_req && fifo_en;

  sfifo_sync_hunt #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_hunt (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_valid    (bit_valid),
    .bit_data     (bit_data),
    .fill_en      (cfg.fill_en),
    .start_always (cfg.start_always),
    .gate_open    (gate_open),
    .sync_hit     (sync_hit),
    .locked       (locked)
  );

  sfifo_bit_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .CW(CW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (bit_valid && gate_open),
    .push_bit   (bit_data),
    .pop_req    (pop_go),
    .pop_data   (pop_data),
    .fill_count (fill_count),
    .push_ok    (push_ok),
    .push_drop  (push_drop),
    .ovf        (fifo_ovf)
  );

  assign irq = (32'(fill_count) >= 32'(irq_threshold(cfg.level)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_data  <= pop_go ? pop_data : '0;
    end
  end

endmodule

// File: rtl/sync_rx_fifo_chk.sv
module sync_rx_fifo_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              fifo_ovf,
  input logic              rsp_valid,
  input logic [BYTE_W-1:0] rsp_data,
  input logic              fifo_en,
  input logic [CW-1:0]     fill_count,
  input logic              push_ok,
  input logic              push_drop,
  input logic              pop_go,
  input logic              rd_req,
  input logic              cfg_wr,
  input logic              cfg_fill_en,
  input logic              locked
);

  AST_STORE_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> cfg_fill_en); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_fill_en && !cfg_wr) |=> locked); // R6
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(pop_go) || $past(cfg_wr))); // R7
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_req)); // R8
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !fifo_en) |=> (rsp_valid && rsp_data == '0)); // R10
  AST_READ_GATED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !fifo_en && !push_ok) |=> $stable(fill_count)); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH)); // R11
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |-> (fill_count == CW'(DEPTH) && !pop_go)); // R11
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> !fifo_ovf); // R11

endmodule

bind sync_rx_fifo sync_rx_fifo_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (irq),
  .fifo_ovf    (fifo_ovf),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .fifo_en     (fifo_en),
  .fill_count  (fill_count),
  .push_ok     (push_ok),
  .push_drop   (push_drop),
  .pop_go      (pop_go),
  .rd_req      (rd_req),
  .cfg_wr      (cfg_wr),
  .cfg_fill_en (cfg_fill_en),
  .locked      (locked)
);

// File: tb/sync_rx_fifo_test.sv
module sync_rx_fifo_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        fifo_en = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        irq, fifo_ovf, glitch_rst_off;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit q[$];

  always #2.5 clk = ~clk;

  sync_rx_fifo uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .fifo_en(fifo_en),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq),
    .fifo_ovf(fifo_ovf), .glitch_rst_off(glitch_rst_off)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [15:0] w, input bit en);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w; fifo_en = en;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; fifo_en = 1'b0;
  endtask

  // Send one bit; 'kept' says whether the requirements say it is stored.
  task automatic put(input bit b, input bit kept);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = b;
    @(posedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
    if (kept && q.size() < 16) q.push_back(b);
  endtask

  task automatic put_word(input logic [15:0] w, input int n, input bit kept);
    for (int i = n - 1; i >= 0; i--) put(w[i], kept);
  endtask

  task automatic rd(input string req, input bit en);
    logic [7:0] e = '0;
    if (en) for (int i = 0; i < 8; i++) if (q.size() > 0) e[7-i] = q.pop_front();
    cmd(16'hB000, en);
    chk(req, rsp_valid, 1);
    chk(req, rsp_data, e);
  endtask

  function automatic bit irq_exp(input int lvl);
    return q.size() >= ((lvl == 0) ? 1 : lvl);
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, filling off
    @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 ovf", fifo_ovf, 0);
    chk("R1 rsp_valid", rsp_valid, 0); chk("R1 glitch", glitch_rst_off, 0);
    put_word(16'hFFFF, 8, 1'b0);
    chk("R1 irq after bits", irq, 0);
    rd("R1 read empty", 1'b1);

    // R4 R7 R8: all levels against all counts in store-always mode
    for (int lvl = 0; lvl < 16; lvl++) begin
      cmd(16'hCA06 | 16'(lvl << 4), 1'b0);
      chk("R7 irq empty", irq, irq_exp(lvl));
      for (int i = 0; i < 16; i++) begin
        put(((lvl * 5 + i * 3) >> 1) & 1, 1'b1);
        chk("R4 R7 irq vs count", irq, irq_exp(lvl));
      end
      rd("R8 read first byte", 1'b1);
      chk("R7 irq after read", irq, irq_exp(lvl));
      rd("R8 read second byte", 1'b1);
      chk("R7 irq drained", irq, 0);
    end

    // R11: overflow drop and clear
    cmd(16'hCAF6, 1'b0);
    put_word(16'hA5C3, 16, 1'b1);
    chk("R11 no ovf at full", fifo_ovf, 0);
    put(1'b1, 1'b0);
    chk("R11 ovf set", fifo_ovf, 1);
    rd("R11 oldest byte kept", 1'b1);
    chk("R11 ovf cleared", fifo_ovf, 0);
    rd("R11 second byte", 1'b1);

    // R9: partial read pads and empties
    cmd(16'hCA16, 1'b0);
    put_word(16'h0016, 5, 1'b1);
    chk("R9 irq with 5 bits", irq, 1);
    rd("R9 partial read", 1'b1);
    chk("R9 irq after partial", irq, 0);
    rd("R9 read after empty", 1'b1);

    // R10: gated read keeps data
    cmd(16'hCA86, 1'b0);
    put_word(16'h0096, 8, 1'b1);
    chk("R10 irq before", irq, 1);
    rd("R10 gated read", 1'b0);
    chk("R10 irq kept", irq, 1);
    rd("R10 later read", 1'b1);

    // R2: other opcodes ignored, bit 3 ignored
    cmd(16'hCAF6, 1'b0);
    put_word(16'h0003, 2, 1'b1);
    cmd(16'hCB16, 1'b0);
    chk("R2 foreign opcode ignored", irq, 0);
    cmd(16'hCA1E, 1'b0);
    chk("R2 level 1 with bit3", irq, 1);
    rd("R2 drain", 1'b1);

    // R12: glitch option bit
    cmd(16'hCA81, 1'b0);
    chk("R12 glitch set", glitch_rst_off, 1);
    cmd(16'hCA80, 1'b0);
    chk("R12 glitch clear", glitch_rst_off, 0);

    // R3: sync mode; short prefix must not lock, then full word does
    cmd(16'hCA82, 1'b0);
    put_word(16'h2DD4, 14, 1'b0);
    put_word(16'h00FF, 8, 1'b0);
    rd("R3 no lock on 14-bit prefix", 1'b1);
    put_word(16'h2DD4, 16, 1'b0);
    put_word(16'h00A5, 8, 1'b1);
    chk("R3 irq level 8", irq, 1);
    rd("R3 first byte after sync", 1'b1);

    // R6: later sync pattern stored as data
    put_word(16'h2DD4, 16, 1'b1);
    rd("R6 sync as data hi", 1'b1);
    rd("R6 sync as data lo", 1'b1);

    // R5: clearing fill enable stops storing
    cmd(16'hCA80, 1'b0);
    put_word(16'h00FF, 8, 1'b0);
    chk("R5 irq after disabled bits", irq, 0);
    rd("R5 nothing stored", 1'b1);

    // R6: re-arm and hunt again
    cmd(16'hCA82, 1'b0);
    put_word(16'h00FF, 8, 1'b0);
    rd("R6 hunting stores nothing", 1'b1);
    put_word(16'h2DD4, 16, 1'b0);
    put_word(16'h005A, 8, 1'b1);
    rd("R6 byte after re-arm", 1'b1);

    finish_run();
  end

endmodule